// File: doc/BRIEF.md
# Sliding-Window Exponent Command Sequencer

This block turns a binary exponent into the ordered list of operations that a modular multiply/square datapath must run to raise a base to that power. The exponent is read from the most significant set bit down to bit 0. Runs of up to three bits that begin and end on a one are folded into one multiply by a stored odd power of the base. The stored powers are the base to the first, third, fifth and seventh power. Each zero bit that lies outside such a run costs one squaring.

The datapath takes the commands one at a time through a valid/ready handshake. It is expected to hold the odd powers already. It starts its accumulator at 1, or loads it straight from the first multiply. A one-cycle done pulse marks the end of the list.

Computing the odd powers, and the modular arithmetic itself, belong to other blocks.

Top module: `swin_exp_sequencer`

## Requirements
- R1: A start pulse seen while no stream is in progress loads the exponent. Zero bits above the highest set bit produce nothing. The first command of a non-empty stream is the multiply for the leading window, with no square before it, and it appears the cycle after start.
- R2: Command codes are fixed. 3'b010 means square the accumulator. 3'b001, 3'b011, 3'b101 and 3'b111 mean multiply by the base to the first, third, fifth and seventh power, so a multiply code equals its odd exponent. No other code is ever presented.
- R3: A window opens on a set bit and spans at most three bits. It is shortened so that its lowest bit is a one. Apart from the leading window, each window issues one square per bit it spans and then one multiply by its value. Each zero bit outside a window issues one square. Windows take no notice of any 4-bit grouping of the exponent.
- R4: For an EXP_W-bit exponent, a stream never holds more than floor(4*EXP_W/3) commands.
- R5: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_code does not change.
- R6: done is high for exactly one cycle. That cycle is the one right after the edge that accepts the last command, and cmd_valid is low in it.
- R7: An all-zero exponent yields no command. done pulses in the cycle after start, which leaves the accumulator at 1.
- R8: A start pulse while a stream is in progress is ignored, and the stream in flight continues unchanged.
- R9: Running the stream in order on an accumulator gives the base raised to the loaded exponent. The first multiply loads the accumulator; each later multiply multiplies it by the matching odd power, and each square squares it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new exponent (used only when idle) |
| exp_in | input | EXP_W | Exponent, sampled with start |
| cmd_valid | output | 1 | A command is presented |
| cmd_ready | input | 1 | Datapath accepts the presented command |
| cmd_code | output | 3 | Operation code (see R2) |
| done | output | 1 | One-cycle pulse after the last command |

## Verification
The case that is hardest to reach from the ports is a window that stalls partway through its square run while a fresh start pulse arrives. The stimulus holds cmd_ready low at random points and injects a start with a different exponent after a few commands have gone. The stream must then match the reference for the original exponent. Dense patterns such as repeating 100 and 101101 push the command count to its bound. Random exponents, shifted to vary the number of leading zeros, are also run through a small modular model to confirm that the stream really computes the power.

// File: rtl/swin_pkg.sv
package swin_pkg;

    // Square the accumulator.
    localparam logic [2:0] CMD_SQR = 3'b010;

    // A multiply command carries its odd exponent directly as the code.
    function automatic logic [2:0] mul_code(input logic [2:0] odd_pow);
        return odd_pow;
    endfunction

endpackage

// File: rtl/swin_lead_scan.sv
// Finds the index of the highest set bit of a vector.
module swin_lead_scan #(
    parameter int W = 64
) (
    input  logic [W-1:0]                         vec,
    output logic [((W > 1) ? $clog2(W) : 1)-1:0] msb_idx,
    output logic                                 any_set
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    always_comb begin
        msb_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) msb_idx = IW'(i);
        end
        any_set = |vec;
    end
endmodule

// File: rtl/swin_window_pick.sv
// Given a set bit at position top, forms the window of up to three bits
// below and including it, trimmed so that its lowest bit is a one.
module swin_window_pick #(
    parameter int W = 64
) (
    input  logic [W-1:0]                         bits,
    input  logic [((W > 1) ? $clog2(W) : 1)-1:0] top,
    output logic [2:0]                           odd_val,
    output logic [1:0]                           win_len
);
    logic [W+1:0] padded;
    logic [2:0]   look;

    // Two zero bits below bit 0, so that a window near the bottom reads zeros.
    assign padded = {bits, 2'b00};
    assign look   = padded[top +: 3];   // look[2]=bit top, look[0]=bit top-2

    always_comb begin
        if (look[2] && look[0]) begin
            odd_val = {1'b1, look[1], 1'b1};
            win_len = 2'd3;
        end else if (look[2] && look[1]) begin
            odd_val = 3'd3;
            win_len = 2'd2;
        end else begin
            odd_val = 3'd1;
            win_len = 2'd1;
        end
    end
endmodule

// File: rtl/swin_exp_sequencer.sv
module swin_exp_sequencer
    import swin_pkg::*;
#(
    parameter int EXP_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] exp_in,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_code,
    output logic             done
);
    localparam int IW        = (EXP_W > 1) ? $clog2(EXP_W) : 1;
    localparam int PW        = $clog2(EXP_W + 1);
    localparam int OP_BOUND  = (4 * EXP_W) / 3;

    typedef struct packed {
        logic [EXP_W-1:0] expo;     // loaded exponent
        logic [PW-1:0]    pos;      // bits [pos-1:0] still to walk
        logic [1:0]       sq_left;  // squares still owed by the open window
        logic [2:0]       pend;     // odd multiply owed after them, 0 = none
        logic             valid;
        logic [2:0]       code;
        logic             done;
    } seq_t;

    seq_t st_d, st_q;

    // Leading window, taken straight from the input port at start.
    logic [IW-1:0] lead_idx;
    logic          lead_any;
    logic [2:0]    lead_odd;
    logic [1:0]    lead_len;

    swin_lead_scan #(.W(EXP_W)) u_lead_scan (
        .vec     (exp_in),
        .msb_idx (lead_idx),
        .any_set (lead_any)
    );

    swin_window_pick #(.W(EXP_W)) u_lead_pick (
        .bits    (exp_in),
        .top     (lead_idx),
        .odd_val (lead_odd),
        .win_len (lead_len)
    );

    // Window that would open at the next unwalked bit.
    logic [IW-1:0] walk_top;
    logic          walk_bit;
    logic [2:0]    walk_odd;
    logic [1:0]    walk_len;

    assign walk_top = (st_q.pos == '0) ? '0 : IW'(st_q.pos - PW'(1));
    assign walk_bit = st_q.expo[walk_top];

    swin_window_pick #(.W(EXP_W)) u_walk_pick (
        .bits    (st_q.expo),
        .top     (walk_top),
        .odd_val (walk_odd),
        .win_len (walk_len)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.valid) begin
            if (start) begin
                st_d.expo = exp_in;
                if (!lead_any) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.valid   = 1'b1;
                    st_d.code    = mul_code(lead_odd);
                    st_d.pos     = PW'(lead_idx) + PW'(1) - PW'(lead_len);
                    st_d.sq_left = 2'd0;
                    st_d.pend    = 3'd0;
                end
            end
        end else if (cmd_ready) begin
            if (st_q.sq_left != 2'd0) begin
                st_d.code    = CMD_SQR;
                st_d.sq_left = st_q.sq_left - 2'd1;
            end else if (st_q.pend != 3'd0) begin
                st_d.code = mul_code(st_q.pend);
                st_d.pend = 3'd0;
            end else if (st_q.pos == '0) begin
                st_d.valid = 1'b0;
                st_d.done  = 1'b1;
            end else if (!walk_bit) begin
                st_d.code = CMD_SQR;
                st_d.pos  = st_q.pos - PW'(1);
            end else begin
                st_d.code    = CMD_SQR;
                st_d.sq_left = walk_len - 2'd1;
                st_d.pend    = walk_odd;
                st_d.pos     = st_q.pos - PW'(walk_len);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid = st_q.valid;
    assign cmd_code  = st_q.code;
    assign done      = st_q.done;

    // ---------------- assertions ----------------
    logic [PW:0] issued_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      issued_q <= '0;
        else if (!st_q.valid && start)   issued_q <= '0;
        else if (cmd_valid && cmd_ready) issued_q <= issued_q + 1'b1;
    end

    a_r1_first_is_mul: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> cmd_code != CMD_SQR);

    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code == CMD_SQR || cmd_code[0]));

    a_r4_op_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (32'(issued_q) + 1 <= OP_BOUND));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code));

    a_r6_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    a_r8_busy_keeps_exp: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && start |=> $stable(st_q.expo));
endmodule

// File: tb/swin_exp_sequencer_bench.sv
`timescale 1ns/1ps
module swin_exp_sequencer_bench;
    localparam int  W     = 24;
    localparam int  BOUND = (4 * W) / 3;
    localparam longint MODP = 1000003;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] exp_in = '0;
    logic         cmd_valid;
    logic         cmd_ready = 1'b0;
    logic [2:0]   cmd_code;
    logic         done;

    int checks = 0;
    int fails  = 0;

    bit [2:0] expq[$];
    bit [2:0] got[$];

    always #2.5 clk = ~clk;

    swin_exp_sequencer #(.EXP_W(W)) u_swin_exp_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference command list from the window rule.
    function automatic void build_ref(input bit [W-1:0] e);
        int  i;
        int  len;
        bit  first;
        bit [2:0] v;
        expq.delete();
        i = -1;
        for (int k = 0; k < W; k++) if (e[k]) i = k;
        first = 1'b1;
        while (i >= 0) begin
            if (!e[i]) begin
                expq.push_back(3'b010);
                i--;
            end else begin
                if (i >= 2 && e[i-2])      begin len = 3; v = {1'b1, e[i-1], 1'b1}; end
                else if (i >= 1 && e[i-1]) begin len = 2; v = 3'd3; end
                else                       begin len = 1; v = 3'd1; end
                if (!first) for (int s = 0; s < len; s++) expq.push_back(3'b010);
                expq.push_back(v);
                first = 1'b0;
                i -= len;
            end
        end
    endfunction

    function automatic longint modpow(input longint b, input bit [W-1:0] e);
        longint r = 1;
        longint x = b % MODP;
        for (int k = 0; k < W; k++) begin
            if (e[k]) r = (r * x) % MODP;
            x = (x * x) % MODP;
        end
        return r;
    endfunction

    function automatic longint run_stream(input longint b);
        longint p [8];
        longint acc = 1;
        p[1] = b % MODP;
        p[3] = (((p[1] * p[1]) % MODP) * p[1]) % MODP;
        p[5] = (((p[3] * p[1]) % MODP) * p[1]) % MODP;
        p[7] = (((p[5] * p[1]) % MODP) * p[1]) % MODP;
        foreach (got[k]) begin
            if (got[k] == 3'b010) acc = (acc * acc) % MODP;
            else                  acc = (acc * p[got[k]]) % MODP;
        end
        return acc;
    endfunction

    task automatic run(input bit [W-1:0] e, input int ready_pct, input bit restart_mid);
        bit       prev_hold = 0;
        bit [2:0] prev_c = 0;
        bit       seen_done = 0;
        bit       restarted = 0;
        bit       rdy;
        int       mism = -1;
        longint   base;
        build_ref(e);
        got.delete();
        @(negedge clk);
        start = 1'b1; exp_in = e; cmd_ready = 1'b0;
        @(negedge clk);
        start = 1'b0; exp_in = W'($urandom);
        if (expq.size() == 0) begin
            check(done && !cmd_valid, "R7", "zero exponent done/valid", {done, cmd_valid}, 2);
            @(negedge clk);
            check(!done && !cmd_valid, "R7", "zero exponent quiet after", {done, cmd_valid}, 0);
            return;
        end
        check(cmd_valid && cmd_code == expq[0], "R1", "first command", cmd_code, expq[0]);
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (prev_hold)
                check(cmd_valid && cmd_code == prev_c, "R5", "stalled command held", cmd_code, prev_c);
            if (done) begin
                seen_done = 1;
                check(!cmd_valid && got.size() == expq.size(), "R6",
                      "done after last accept", got.size(), expq.size());
                break;
            end
            if (restart_mid && !restarted && got.size() == 3) begin
                start = 1'b1; exp_in = ~e; restarted = 1;
            end
            rdy = ($urandom_range(99) < ready_pct);
            cmd_ready = rdy;
            if (cmd_valid && rdy) got.push_back(cmd_code);
            prev_hold = cmd_valid && !rdy;
            prev_c    = cmd_code;
            @(negedge clk);
            start = 1'b0;
        end
        cmd_ready = 1'b0;
        check(seen_done, "R6", "done seen", seen_done, 1);
        @(negedge clk);
        check(!done, "R6", "done one cycle only", done, 0);
        for (int k = 0; k < expq.size(); k++)
            if (mism < 0 && (k >= got.size() || got[k] != expq[k])) mism = k;
        check(mism < 0 && got.size() == expq.size(), restart_mid ? "R8" : "R3",
              "stream matches window rule (first bad index)", mism, -1);
        check(got.size() <= BOUND, "R4", "command count bound", got.size(), BOUND);
        base = longint'($urandom_range(1000000, 2));
        check(run_stream(base) == modpow(base, e), "R9", "stream result",
              run_stream(base), modpow(base, e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WD", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check(!cmd_valid && !done, "R6", "reset idle", {cmd_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(24'h38131F, 100, 0);   // R3 windows cross nibble boundaries
        run(24'h38131F, 50, 0);
        run(24'h000000, 100, 0);   // R7
        run(24'h000001, 100, 0);   // R1 lone leading window at bit 0
        run(24'h800000, 70, 0);    // R1 long square tail
        run(24'hFFFFFF, 100, 0);   // R4
        run(24'h924924, 60, 0);    // R4 worst density
        run(24'hB6DB6D, 60, 0);    // R4
        run(24'h000005, 40, 0);    // R2 code 101
        run(24'h38131F, 40, 1);    // R8 start while busy
        run(24'hA5A5A5, 30, 1);    // R8
        for (int n = 0; n < 40; n++) begin
            bit [W-1:0] e;
            e = W'($urandom) >> $urandom_range(20, 0);
            run(e, (n % 2) ? 100 : 55, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule